// File: doc/BRIEF.md
# Host Mailbox Buffer Controller

This block sits between an external host and an embedded acquisition processor. The host reaches it through a byte-wide register port. That port has three registers: a buffer pointer, a buffer data window and a request status byte. The host sets the pointer to zero and streams a request message through the data window: first a command byte, then a message identifier, then the payload. It then raises the request-pending flag. That flag can only be changed by a status write that also carries a load-enable bit. The processor sees a one-cycle start pulse and reads the request from the buffer. It writes its response, which has a two-byte header followed by the payload, back into the same buffer, and then clears the pending flag. The host polls until the flag reads zero and reads the response from address zero.

A single pointer serves both reads and writes and advances after every data access. It wraps at the buffer depth. The block sets no access protection: data writes from the host are accepted even while a request is pending. The default depth is 128 bytes.

Top module: `hab_mailbox`

## Requirements
- R1: After synchronous reset, the pointer is 0, request-pending is 0, req_start is 0 and host_rdata is 0.
- R2: A host write to offset 0xA6 loads the pointer from the low log2(DEPTH) bits of the written byte. A read of 0xA6 returns the pointer, zero-extended.
- R3: A host write to offset 0xA7 stores the byte at the pointer and advances the pointer by one. The stored byte is visible on the processor read port at that address.
- R4: A host read of offset 0xA7 returns the byte at the pointer on host_rdata one clock after the read strobe, and advances the pointer by one. host_rdata holds its value while no read strobe is given.
- R5: The pointer wraps from DEPTH-1 to 0 when a data access advances it.
- R6: A host write to offset 0xA8 with bit 1 (load enable) set loads request-pending from bit 0 of the written byte.
- R7: A host write to 0xA8 with bit 1 clear leaves request-pending unchanged. A read of 0xA8 returns request-pending in bit 0 and zeros in bits 7..1, so the load-enable bit always reads back as 0.
- R8: proc_done clears request-pending. When a host status write with load enable occurs in the same cycle, the host write decides the flag.
- R9: req_start is high for exactly one cycle, in the first cycle that request-pending reads 1 after being 0. Writing 1 while the flag is already 1 gives no pulse.
- R10: Processor writes are visible to host data reads. When the host and the processor write the same buffer address in one cycle, the host byte is kept.
- R11: Host data writes are accepted while request-pending is set.
- R12: Host accesses to any other offset change no state and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ofs | input | 8 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| proc_addr | input | ADDR_W | Processor buffer address |
| proc_wr | input | 1 | Processor buffer write strobe |
| proc_wdata | input | 8 | Processor write byte |
| proc_rdata | output | 8 | Processor read byte at proc_addr, combinational |
| proc_done | input | 1 | Processor clears request-pending |
| req_pending | output | 1 | Request-pending flag |
| req_start | output | 1 | One-cycle pulse when a request begins |

## Verification
The bench targets the status guard. A design that ignored load enable would drop or raise the flag on a plain status write, and one that echoed the load-enable bit would read back 0x03 instead of 0x01. It checks the pointer at the wrap point, where a missing wrap leaves the pointer past the end and sends the next byte to the wrong place. It also checks a pointer that fails to advance on reads, which returns the same response byte over and over. It drives collisions in a single cycle, both clear against set and processor write against host write, where a wrong priority loses the new request or the host byte. It also checks that the start pulse lasts one cycle and does not fire again on a repeated set.

// File: rtl/hab_pkg.sv
package hab_pkg;

    localparam logic [7:0] OFS_PTR  = 8'hA6;
    localparam logic [7:0] OFS_DATA = 8'hA7;
    localparam logic [7:0] OFS_STAT = 8'hA8;

    localparam int PEND_BIT = 0;
    localparam int LOAD_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_STAT = 2'd3
    } hsel_e;

    typedef struct packed {
        logic       ptr_load;
        logic       data_wr;
        logic       data_step;
        logic       stat_wr;
        logic       rd;
        hsel_e      sel;
        logic [7:0] wdata;
    } host_op_t;

    function automatic hsel_e decode_sel(input logic [7:0] ofs);
        case (ofs)
            OFS_PTR:  return SEL_PTR;
            OFS_DATA: return SEL_DATA;
            OFS_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input logic pend);
        logic [7:0] b;
        b = 8'h00;
        b[PEND_BIT] = pend;
        return b;
    endfunction

endpackage

// File: rtl/hab_decode.sv
module hab_decode
    import hab_pkg::*;
(
    input  logic [7:0] host_ofs,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output host_op_t   op
);
    hsel_e sel;

    always_comb begin
        sel          = decode_sel(host_ofs);
        op           = '0;
        op.sel       = sel;
        op.wdata     = host_wdata;
        op.rd        = host_rd;
        op.ptr_load  = host_wr && (sel == SEL_PTR);
        op.data_wr   = host_wr && (sel == SEL_DATA);
        op.stat_wr   = host_wr && (sel == SEL_STAT);
        op.data_step = (host_wr || host_rd) && (sel == SEL_DATA);
    end
endmodule

// File: rtl/hab_pointer.sv
module hab_pointer
    import hab_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  host_op_t          op,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
    localparam bit POW2 = (DEPTH == (1 << ADDR_W));

    logic [ADDR_W-1:0] ptr_inc;
    logic [ADDR_W-1:0] load_val;

    generate
        if (POW2) begin : g_pow2
            assign ptr_inc  = ptr + 1'b1;
            assign load_val = op.wdata[ADDR_W-1:0];
        end else begin : g_cmp
            assign ptr_inc  = (ptr == LAST) ? '0 : ptr + 1'b1;
            assign load_val = (op.wdata[ADDR_W-1:0] > LAST) ? '0 : op.wdata[ADDR_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)               ptr <= '0;
        else if (op.ptr_load)  ptr <= load_val;
        else if (op.data_step) ptr <= ptr_inc;
    end

    // R3 / R4 / R5: every data access moves the pointer by one, wrapping at the end
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (op.data_step && !op.ptr_load) |=>
            (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    a_r5_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);

    // R2: the pointer takes a written value and holds it while idle
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!op.ptr_load && !op.data_step) |=> $stable(ptr));
endmodule

// File: rtl/hab_buffer.sv
module hab_buffer #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rbyte,
    input  logic              proc_we,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic [7:0]        proc_wdata,
    output logic [7:0]        proc_rbyte
);
    logic [7:0] mem [DEPTH];
    logic       proc_blocked;

    assign proc_blocked = host_we && (host_addr == proc_addr);

    always_ff @(posedge clk) begin
        if (proc_we && !proc_blocked) mem[proc_addr] <= proc_wdata;
        if (host_we)                  mem[host_addr] <= host_wdata;
    end

    assign host_rbyte = mem[host_addr];
    assign proc_rbyte = mem[proc_addr];

    // R10: on a same-address collision the host byte is the one stored
    a_r10_host_wins: assert property (@(posedge clk)
        (host_we && proc_we && proc_blocked) |=> (proc_rbyte == $past(host_wdata)) || (proc_addr != $past(proc_addr)));
endmodule

// File: rtl/hab_flags.sv
module hab_flags
    import hab_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_op_t op,
    input  logic     proc_done,
    output logic     pend,
    output logic     start
);
    logic load_ev;
    logic set_val;

    assign load_ev = op.stat_wr && op.wdata[LOAD_BIT];
    assign set_val = op.wdata[PEND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            start <= 1'b0;
        end else begin
            if (load_ev)        pend <= set_val;
            else if (proc_done) pend <= 1'b0;
            start <= load_ev && set_val && !pend;
        end
    end

    // R6: a guarded status write sets the flag to the written bit
    a_r6_guarded_load: assert property (@(posedge clk) disable iff (rst)
        load_ev |=> (pend == $past(set_val)));

    // R7: without the guard or a clear the flag keeps its value
    a_r7_unguarded_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_ev && !proc_done) |=> $stable(pend));

    // R8: a processor clear drops the flag unless the host loads it
    a_r8_proc_clear: assert property (@(posedge clk) disable iff (rst)
        (proc_done && !load_ev) |=> !pend);

    // R9: the start pulse lasts one cycle and marks a rise of the flag
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        start |-> (pend && !$past(pend)));
endmodule

// File: rtl/hab_mailbox.sv
module hab_mailbox
    import hab_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        host_ofs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic              proc_wr,
    input  logic [7:0]        proc_wdata,
    output logic [7:0]        proc_rdata,
    input  logic              proc_done,
    output logic              req_pending,
    output logic              req_start
);
    host_op_t          op;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        buf_byte;
    logic [7:0]        rd_mux;

    hab_decode u_decode (
        .host_ofs   (host_ofs),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .op         (op)
    );

    hab_pointer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pointer (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .ptr (ptr)
    );

    hab_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buffer (
        .clk        (clk),
        .host_we    (op.data_wr),
        .host_addr  (ptr),
        .host_wdata (op.wdata),
        .host_rbyte (buf_byte),
        .proc_we    (proc_wr),
        .proc_addr  (proc_addr),
        .proc_wdata (proc_wdata),
        .proc_rbyte (proc_rdata)
    );

    hab_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .proc_done (proc_done),
        .pend      (req_pending),
        .start     (req_start)
    );

    always_comb begin
        case (op.sel)
            SEL_PTR:  rd_mux = 8'(ptr);
            SEL_DATA: rd_mux = buf_byte;
            SEL_STAT: rd_mux = status_byte(req_pending);
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        host_rdata <= 8'h00;
        else if (op.rd) host_rdata <= rd_mux;
    end

    // R4: read data only changes on a read strobe
    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    // R7: status reads never show anything above the pending bit
    a_r7_status_clean: assert property (@(posedge clk) disable iff (rst)
        (host_rd && op.sel == SEL_STAT) |=> (host_rdata[7:1] == 7'd0));

    // R12: reads of unknown offsets return zero
    a_r12_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rd && op.sel == SEL_NONE) |=> (host_rdata == 8'h00));
endmodule

// File: tb/hab_mailbox_test.sv
module hab_mailbox_test;
    localparam int DEPTH  = 128;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        host_ofs = 8'h00;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [7:0]        host_wdata = 8'h00;
    logic [7:0]        host_rdata;
    logic [ADDR_W-1:0] proc_addr = '0;
    logic              proc_wr = 1'b0;
    logic [7:0]        proc_wdata = 8'h00;
    logic [7:0]        proc_rdata;
    logic              proc_done = 1'b0;
    logic              req_pending;
    logic              req_start;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    hab_mailbox #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .host_ofs(host_ofs), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .proc_addr(proc_addr), .proc_wr(proc_wr), .proc_wdata(proc_wdata),
        .proc_rdata(proc_rdata), .proc_done(proc_done),
        .req_pending(req_pending), .req_start(req_start)
    );

    // vector: [17:16] op (0 write, 1 read and compare), [15:8] offset, [7:0] data or expected
    localparam int NV = 20;
    localparam logic [17:0] VECS [NV] = '{
        {2'd0, 8'hA6, 8'h00},  // R2 pointer to 0
        {2'd0, 8'hA7, 8'h11},  // R3 command byte
        {2'd0, 8'hA7, 8'h22},  // R3 message id
        {2'd0, 8'hA7, 8'h33},  // R3 payload
        {2'd1, 8'hA6, 8'h03},  // R3 pointer advanced three times
        {2'd0, 8'hA6, 8'h00},
        {2'd1, 8'hA7, 8'h11},  // R4 read back with auto increment
        {2'd1, 8'hA7, 8'h22},
        {2'd1, 8'hA7, 8'h33},
        {2'd1, 8'hA6, 8'h03},  // R4 reads advance the pointer
        {2'd0, 8'hA6, 8'hC5},  // R2 only low bits kept: 0x45
        {2'd1, 8'hA6, 8'h45},
        {2'd0, 8'hA8, 8'h03},  // R6 guarded set
        {2'd1, 8'hA8, 8'h01},  // R7 load enable reads as 0
        {2'd0, 8'hA8, 8'h00},  // R7 unguarded write ignored
        {2'd1, 8'hA8, 8'h01},
        {2'd0, 8'hA8, 8'h02},  // R6 guarded clear
        {2'd1, 8'hA8, 8'h00},
        {2'd0, 8'h10, 8'hFF},  // R12 unknown offset write
        {2'd1, 8'h10, 8'h00}   // R12 unknown offset reads 0
    };

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic hwrite(input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        host_ofs = ofs; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] ofs, output logic [7:0] d);
        @(negedge clk);
        host_ofs = ofs; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata", host_rdata, 8'h00);
        check("R1 pending", req_pending, 0);
        check("R1 start", req_start, 0);
        hread(8'hA6, rb);
        check("R1 pointer", rb, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][17:16] == 2'd0) hwrite(VECS[i][15:8], VECS[i][7:0]);
            else begin
                hread(VECS[i][15:8], rb);
                check($sformatf("R2-table vec%0d", i), rb, VECS[i][7:0]);
            end
        end
        hread(8'hA6, rb);
        check("R12 pointer untouched", rb, 8'h45);

        // R9 start pulse
        hwrite(8'hA8, 8'h03);
        check("R9 pulse high", req_start, 1);
        check("R9 pending high", req_pending, 1);
        @(negedge clk);
        check("R9 pulse one cycle", req_start, 0);
        hwrite(8'hA8, 8'h03);
        check("R9 no pulse on re-set", req_start, 0);

        // R11 host writes while pending; processor sees them
        hwrite(8'hA6, 8'h08);
        hwrite(8'hA7, 8'h9D);
        proc_addr = ADDR_W'(8);
        #0;
        check("R11 write while pending", proc_rdata, 8'h9D);

        // R8 processor clear
        @(negedge clk); proc_done = 1'b1;
        @(negedge clk); proc_done = 1'b0;
        check("R8 clear", req_pending, 0);

        // R8 clear and guarded set in one cycle: host decides
        @(negedge clk);
        proc_done = 1'b1; host_ofs = 8'hA8; host_wdata = 8'h03; host_wr = 1'b1;
        @(negedge clk);
        proc_done = 1'b0; host_wr = 1'b0;
        check("R8 host set wins", req_pending, 1);
        check("R9 pulse on collision set", req_start, 1);

        // R10 processor response visible to host
        @(negedge clk); proc_wr = 1'b1; proc_addr = ADDR_W'(0); proc_wdata = 8'hC3;
        @(negedge clk); proc_addr = ADDR_W'(1); proc_wdata = 8'h3C;
        @(negedge clk); proc_wr = 1'b0;
        hwrite(8'hA6, 8'h00);
        hread(8'hA7, rb);
        check("R10 response byte0", rb, 8'hC3);
        hread(8'hA7, rb);
        check("R10 response byte1", rb, 8'h3C);

        // R10 same-address collision keeps host byte
        hwrite(8'hA6, 8'h05);
        @(negedge clk);
        host_ofs = 8'hA7; host_wdata = 8'hAA; host_wr = 1'b1;
        proc_wr = 1'b1; proc_addr = ADDR_W'(5); proc_wdata = 8'hBB;
        @(negedge clk);
        host_wr = 1'b0; proc_wr = 1'b0;
        check("R10 collision host wins", proc_rdata, 8'hAA);

        // R5 wrap
        hwrite(8'hA6, 8'(DEPTH - 1));
        hwrite(8'hA7, 8'h5A);
        hread(8'hA6, rb);
        check("R5 wrap after write", rb, 8'h00);
        hwrite(8'hA6, 8'(DEPTH - 1));
        hread(8'hA7, rb);
        check("R5 last byte", rb, 8'h5A);
        hread(8'hA6, rb);
        check("R5 wrap after read", rb, 8'h00);

        // R4 rdata holds without a read strobe
        repeat (3) @(negedge clk);
        check("R4 rdata hold", host_rdata, 8'h00);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset clears pending", req_pending, 0);
        hread(8'hA6, rb);
        check("R1 reset clears pointer", rb, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule